// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM of 2^18 four-bit words. The host hands over one read or write at a time through a valid/ready handshake. The block then produces the RAM's active-low select, write strobe and output gate, and puts the address on the address pins. It also manages the shared four-bit data pins. Read data comes back to the host with a one-cycle valid pulse.

Every analog minimum is given as a time parameter in picoseconds. The block converts each one into a whole number of clock cycles, rounding up. The write strobe is qualified by write enable, and the output gate stays high for the whole write. The block's own data drivers are on only during the strobe and for one hold cycle after it. Between operations the RAM is deselected and so sits in standby. This leaves at least one released cycle before the output gate can open, so the host side and the RAM never drive the data pins together.

Top module: `asram_seq`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1, `rsp_valid` is 0 and `mem_dq` is not driven by the block.
- R2: A request is taken only on a clock edge where both `req_valid` and `req_ready` are 1. From the next cycle `req_ready` stays 0 until the operation has finished.
- R3: During a write, `mem_ce_n` and `mem_we_n` are 0 together and `mem_oe_n` is 1. `mem_dq` carries the request data for the whole strobe and for one cycle after `mem_we_n` returns to 1.
- R4: During a read, `mem_ce_n` and `mem_oe_n` are 0 and `mem_we_n` is 1 for exactly RD_CYC cycles. `rsp_valid` is then 1 for one cycle, RD_CYC+1 cycles after the accepting edge, with the word sampled from the RAM.
- R5: The block drives `mem_dq` only while `mem_oe_n` is 1. In the cycle before `mem_oe_n` falls, `mem_dq` is fully released.
- R6: `mem_addr` does not change while `mem_ce_n` is 0.
- R7: The strobe length in cycles is WP_CYC = ceil(T_WP_PS / T_CLK_PS). The read length is RD_CYC = ceil(T_RD_PS / T_CLK_PS).
- R8: Whenever `req_ready` is 1, `mem_ce_n` is 1, so the RAM is in standby while no operation is in progress.
- R9: A read of any address returns the data last written there. This holds for back-to-back writes and reads in either order.
- R10: `mem_we_n` and `mem_oe_n` are never 0 at the same time, and `mem_we_n` is never 0 while `mem_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_dq | inout | DATA_W | RAM data pins |

## Verification
The bench builds the block with an 8-bit address, an 8 ns clock, a 17 ns strobe minimum and a 15 ns read minimum. This gives a three-cycle strobe and a two-cycle read, so both rounding paths are exercised and the two lengths differ. The small address space lets every location be written and then read back through a behavioural RAM model. A further stream alternates writes and reads over scattered addresses, which covers each direction of bus turnaround. A pin monitor measures every strobe and read window and checks release before each output-gate opening.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WSTRB = 3'd1,
      ST_WHOLD = 3'd2,
      ST_RACC  = 3'd3,
      ST_RDONE = 3'd4
   } seq_state_t;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic drv;
      logic rdy;
      logic rsp;
   } pin_ctl_t;

   function automatic int ceil_cycles(input int t_ps, input int clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic pin_ctl_t decode_pins(input seq_state_t st);
      pin_ctl_t p;
      p.ce_n = !(st == ST_WSTRB || st == ST_WHOLD || st == ST_RACC);
      p.we_n = (st != ST_WSTRB);
      p.oe_n = (st != ST_RACC);
      p.drv  = (st == ST_WSTRB || st == ST_WHOLD);
      p.rdy  = (st == ST_IDLE);
      p.rsp  = (st == ST_RDONE);
      return p;
   endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_pad.sv
module asram_pad #(
   parameter int DATA_W = 4
) (
   input  logic              en,
   input  logic [DATA_W-1:0] dout,
   output logic [DATA_W-1:0] din,
   inout  wire  [DATA_W-1:0] pad
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign pad[i] = en ? dout[i] : 1'bz;
      assign din[i] = pad[i];
   end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 4,
   parameter int T_CLK_PS = 8000,
   parameter int T_WP_PS  = 12000,
   parameter int T_DS_PS  = 7000,
   parameter int T_RD_PS  = 15000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   inout  wire  [DATA_W-1:0] mem_dq
);
   localparam int WP_CYC = (ceil_cycles(T_WP_PS, T_CLK_PS) < 1) ? 1 : ceil_cycles(T_WP_PS, T_CLK_PS);
   localparam int RD_CYC = (ceil_cycles(T_RD_PS, T_CLK_PS) < 1) ? 1 : ceil_cycles(T_RD_PS, T_CLK_PS);
   localparam int MAX_CYC = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
   localparam int CNT_W = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("asram_seq: widths must be positive");
   end
   if (T_CLK_PS <= 0) begin : g_bad_clk
      $error("asram_seq: clock period must be positive");
   end
   if (T_DS_PS > T_WP_PS) begin : g_bad_ds
      $error("asram_seq: data setup cannot exceed strobe width");
   end

   seq_state_t st_q, st_d;
   pin_ctl_t   ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q, dq_in;
   logic tmr_load, tmr_done, accept;

   assign accept = req_valid && ctl_q.rdy;

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      unique case (st_q)
         ST_IDLE: if (accept) begin
            tmr_load = 1'b1;
            st_d     = req_write ? ST_WSTRB : ST_RACC;
         end
         ST_WSTRB: if (tmr_done) st_d = ST_WHOLD;
         ST_WHOLD: st_d = ST_IDLE;
         ST_RACC:  if (tmr_done) st_d = ST_RDONE;
         ST_RDONE: st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         ctl_q <= decode_pins(ST_IDLE);
      end else begin
         st_q  <= st_d;
         ctl_q <= decode_pins(st_d);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (st_q == ST_RACC && tmr_done)
         rdata_q <= dq_in;
   end

   asram_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (req_write ? WP_LD : RD_LD),
      .done     (tmr_done)
   );

   asram_pad #(.DATA_W(DATA_W)) u_pad (
      .en   (ctl_q.drv),
      .dout (wdata_q),
      .din  (dq_in),
      .pad  (mem_dq)
   );

   assign req_ready = ctl_q.rdy;
   assign rsp_valid = ctl_q.rsp;
   assign rsp_rdata = rdata_q;
   assign mem_addr  = addr_q;
   assign mem_ce_n  = ctl_q.ce_n;
   assign mem_we_n  = ctl_q.we_n;
   assign mem_oe_n  = ctl_q.oe_n;
endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
   parameter int ADDR_W = 18,
   parameter int WP_CYC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              drv
);
   logic [15:0] we_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         we_run <= '0;
      else if (!mem_we_n)
         we_run <= we_run + 1'b1;
      else
         we_run <= '0;
   end

   a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_we_n && mem_oe_n));

   a_r8_standby: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n);

   a_r10_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   a_r10_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);

   a_r5_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
      drv |-> mem_oe_n);

   a_r5_release_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(drv));

   a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

   a_r7_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == 16'(WP_CYC)));

   a_r4_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind asram_seq asram_seq_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .drv       (ctl_q.drv)
);

// File: tb/asram_seq_test.sv
module asram_seq_test;
   localparam int AW = 8;
   localparam int DW = 4;
   localparam int TCLK = 8000;
   localparam int TWP = 17000;
   localparam int TRD = 15000;
   localparam int WP = (TWP + TCLK - 1) / TCLK;
   localparam int RD = (TRD + TCLK - 1) / TCLK;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   wire  [DW-1:0] mem_dq;

   int vectors = 0;
   int errors = 0;
   logic [DW-1:0] exp_wd = '0;
   logic [DW-1:0] ram [0:(1<<AW)-1];
   logic [DW-1:0] shadow [0:(1<<AW)-1];

   always #4 clk = ~clk;

   asram_seq #(.ADDR_W(AW), .DATA_W(DW), .T_CLK_PS(TCLK), .T_WP_PS(TWP),
               .T_DS_PS(7000), .T_RD_PS(TRD)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq));

   // behavioural RAM: standby, read, write, output disable
   assign mem_dq = (!mem_ce_n && mem_we_n && !mem_oe_n) ? ram[mem_addr] : 'z;
   always @* if (!mem_ce_n && !mem_we_n) ram[mem_addr] = mem_dq;

   task automatic check(input logic ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // pin monitor
   logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_dqz = 1'b1;
   logic [AW-1:0] prev_addr = '0;
   int we_run = 0, oe_run = 0;
   always @(negedge clk) if (rst_n) begin
      if (!mem_we_n) begin
         check(!mem_ce_n && mem_oe_n, "R3 pins in strobe", {mem_ce_n, mem_oe_n}, 1);
         check(mem_dq === exp_wd, "R3 data in strobe", mem_dq, exp_wd);
         we_run++;
      end else if (!prev_we) begin
         check(we_run == WP, "R7 strobe cycles", we_run, WP);
         check(mem_dq === exp_wd, "R3 data hold", mem_dq, exp_wd);
         we_run = 0;
      end
      if (!mem_oe_n) begin
         if (prev_oe) check(prev_dqz, "R5 release before read", prev_dqz, 1);
         oe_run++;
      end else if (!prev_oe) begin
         check(oe_run == RD, "R4 read cycles", oe_run, RD);
         oe_run = 0;
      end
      if (!mem_ce_n && !prev_ce)
         check(mem_addr == prev_addr, "R6 address stable", mem_addr, prev_addr);
      if (req_ready) check(mem_ce_n, "R8 standby", mem_ce_n, 1);
      check(!(!mem_we_n && !mem_oe_n), "R10 strobe/gate", {mem_we_n, mem_oe_n}, 3);
      prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n;
      prev_addr = mem_addr; prev_dqz = (mem_dq === 4'bzzzz);
   end

   task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      if (wr) exp_wd = d;
      @(posedge clk); #1;
      req_valid = 1'b0;
      req_addr = ~a; req_wdata = ~d;
      @(negedge clk);
      check(!req_ready, "R2 busy after accept", req_ready, 0);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      issue(1'b1, a, d);
      shadow[a] = d;
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      int lat = 1;
      issue(1'b0, a, '0);
      while (!rsp_valid && lat < 20) begin @(negedge clk); lat++; end
      check(lat == RD + 1, "R4 response latency", lat, RD + 1);
      check(rsp_rdata == shadow[a], "R9 read data", rsp_rdata, shadow[a]);
      @(negedge clk);
      check(!rsp_valid, "R4 single pulse", rsp_valid, 0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !rsp_valid,
            "R1 reset pins", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, rsp_valid}, 5'b11110);
      check(mem_dq === 4'bzzzz, "R1 bus released", mem_dq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && mem_ce_n, "R1 after reset", {req_ready, mem_ce_n}, 3);
      for (int a = 0; a < (1 << AW); a++)
         do_write(AW'(a), DW'((a & 15) ^ (a >> 4) ^ 5));
      for (int a = 0; a < (1 << AW); a++)
         do_read(AW'(a));
      begin
         logic [AW-1:0] x = 8'h3b;
         for (int k = 0; k < 96; k++) begin
            x = x * 8'd29 + 8'd17;
            do_write(x, DW'(k * 3 + 1));
            do_read(x);
            do_read(x ^ 8'h55);
         end
      end
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule